// File: doc/BRIEF.md
# Converter Startup and Fault Supervisor

This block sequences a two-stage power converter: a buck stage followed by a push-pull stage. It has no analog parts. It reads seven digitised status flags from comparators elsewhere on the chip:

- the supply at its regulation level;
- the supply above its minimum (falling) level;
- the reference good;
- the soft-start voltage above its shutdown level;
- the line input inside its operating range;
- the die over its temperature trip point;
- the die cooled below its release point.

From these it drives the enable for the buck control logic, the enable for the push-pull driver logic, a request to discharge the soft-start capacitor, the switch for the line-hysteresis current, and the enables for the bias regulator and the reference.

Each flag goes through a synchroniser and a persistence filter before the state machine sees it. The state machine has five states: idle, ramping, running, faulted and over-temperature. The two stages shut down by different rules. Line-range and soft-start faults stop only the buck stage. The push-pull stage follows the reference, and only the over-temperature state overrides it. After a supply or line fault, the block asks for the soft-start capacitor to be discharged. It re-arms only when the fault has cleared and the soft-start flag has dropped, so each restart gets a fresh ramp.

Top module: `cvtr_supervisor`

## Requirements
- R1: After reset, `state_oh` is 5'b00001 (idle), `buck_en` is 0, `ss_reset` is 1 and `ref_en` is 1.
- R2: A raw flag change reaches the logic only after it has held for FILT_LEN (default 4) consecutive clock cycles; a shorter pulse has no effect on any output. `hyst_en` takes a new `line_good` value on the (2+FILT_LEN)th rising edge after the change.
- R3: `buck_en` is 1 only in the running state. The running state is reached only from the ramping state, with supply-at-regulation, reference-good, soft-start-armed and line-good all true.
- R4: In the running or ramping state, a loss of supply-above-minimum or of line-good moves the block to the faulted state, with `buck_en` 0 and `ss_reset` 1. The faulted state leaves for the ramping state only when supply-at-regulation, line-good and reference-good are true and soft-start-armed is false.
- R5: In the running state, a soft-start-armed drop returns the block to the ramping state with `buck_en` 0 and `ss_reset` 0. No discharge is requested.
- R6: A loss of reference-good in any state other than over-temperature moves the block to the idle state, with `buck_en` and `pp_en` both 0.
- R7: `pp_en` equals filtered reference-good whenever the block is not in the over-temperature state. It does not depend on line-good or soft-start-armed.
- R8: `hyst_en` equals filtered line-good.
- R9: `tj_over` moves the block from any state to over-temperature. There `buck_en`, `pp_en`, `bias_en` and `ref_en` are 0 and `ss_reset` is 1. The block leaves only to idle, and only when `tj_over` is 0 and `tj_cooled` is 1.
- R10: `bias_en` is filtered line-good gated off in the over-temperature state. `ref_en` is 1 in every state except over-temperature and does not depend on line-good.
- R11: `state_oh` is one-hot, with bit 0 idle, bit 1 ramping, bit 2 running, bit 3 faulted and bit 4 over-temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_at_reg | input | 1 | Supply at regulation level (asynchronous) |
| vcc_above_min | input | 1 | Supply above falling threshold (asynchronous) |
| vref_good | input | 1 | Reference in regulation (asynchronous) |
| ss_armed | input | 1 | Soft-start above shutdown level (asynchronous) |
| line_good | input | 1 | Line input within range (asynchronous) |
| tj_over | input | 1 | Die above temperature trip (asynchronous) |
| tj_cooled | input | 1 | Die below temperature release point (asynchronous) |
| buck_en | output | 1 | Enable for buck stage control |
| pp_en | output | 1 | Enable for push-pull drivers |
| ss_reset | output | 1 | Request to discharge / hold soft-start |
| hyst_en | output | 1 | Switch for line-threshold hysteresis current |
| bias_en | output | 1 | Bias regulator enable |
| ref_en | output | 1 | Reference enable |
| state_oh | output | 5 | One-hot supervisor state |

## Verification
A raw flag change reaches the filtered flags on the (2+FILT_LEN)th rising edge after the change. `hyst_en`, `pp_en` and `bias_en` are decoded from the filtered flags, so they change on that same edge. The state and `buck_en` follow one edge later for each state hop. The longest path, idle to ramping to running, therefore settles within FILT_LEN+4 edges. The bench drives inputs on falling edges and samples on falling edges. For the latency check it samples `hyst_en` on the falling edge just before and just after edge 2+FILT_LEN. All other checks wait a fixed FILT_LEN+8 edges, which covers the longest path. Glitch tests hold a flag for FILT_LEN-1 cycles and then wait the full settling time before confirming that nothing moved.

// File: rtl/cvtr_sup_pkg.sv
package cvtr_sup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RAMP    = 3'd1,
        ST_RUN     = 3'd2,
        ST_FAULT   = 3'd3,
        ST_THERMAL = 3'd4
    } sup_state_e;

    localparam int NUM_STATES = 5;

    typedef struct packed {
        logic tj_cooled;
        logic tj_over;
        logic line_good;
        logic ss_armed;
        logic vref_good;
        logic vcc_above_min;
        logic vcc_at_reg;
    } sup_flags_t;

    localparam int NUM_FLAGS = $bits(sup_flags_t);

    function automatic logic [NUM_STATES-1:0] state_to_oh(input sup_state_e s);
        logic [NUM_STATES-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    function automatic logic requests_discharge(input sup_state_e s);
        return (s == ST_IDLE) || (s == ST_FAULT) || (s == ST_THERMAL);
    endfunction

endpackage

// File: rtl/cvtr_sup_filter.sv
module cvtr_sup_filter #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    logic [STAGES-1:0] sync_q;
    logic              synced;
    logic [CNT_W-1:0]  cnt_q;
    logic              filt_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], din};
    end

    assign synced = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (synced == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            filt_q <= synced;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = filt_q;
endmodule

// File: rtl/cvtr_sup_fsm.sv
module cvtr_sup_fsm
    import cvtr_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sup_flags_t flg,
    output sup_state_e state
);
    sup_state_e state_q, state_d;
    logic uv_fault, ready_to_ramp, ready_to_run, rearm_ok, cool_ok;

    assign uv_fault      = !flg.vcc_above_min || !flg.line_good;
    assign ready_to_ramp = flg.vcc_at_reg && flg.vref_good && flg.line_good;
    assign ready_to_run  = flg.ss_armed && flg.vcc_at_reg;
    assign rearm_ok      = ready_to_ramp && !flg.ss_armed;
    assign cool_ok       = !flg.tj_over && flg.tj_cooled;

    always_comb begin
        state_d = state_q;
        if (flg.tj_over && state_q != ST_THERMAL) begin
            state_d = ST_THERMAL;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ready_to_ramp) state_d = ST_RAMP;
                end
                ST_RAMP: begin
                    if (!flg.vref_good)     state_d = ST_IDLE;
                    else if (uv_fault)      state_d = ST_FAULT;
                    else if (ready_to_run)  state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!flg.vref_good)     state_d = ST_IDLE;
                    else if (uv_fault)      state_d = ST_FAULT;
                    else if (!flg.ss_armed) state_d = ST_RAMP;
                end
                ST_FAULT: begin
                    if (!flg.vref_good)     state_d = ST_IDLE;
                    else if (rearm_ok)      state_d = ST_RAMP;
                end
                ST_THERMAL: begin
                    if (cool_ok) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/cvtr_sup_decode.sv
module cvtr_sup_decode
    import cvtr_sup_pkg::*;
(
    input  sup_state_e             state,
    input  logic                   ref_ok,
    input  logic                   line_ok,
    output logic                   buck_en,
    output logic                   pp_en,
    output logic                   ss_reset,
    output logic                   hyst_en,
    output logic                   bias_en,
    output logic                   ref_en,
    output logic [NUM_STATES-1:0]  state_oh
);
    logic hot;

    assign hot      = (state == ST_THERMAL);
    assign buck_en  = (state == ST_RUN);
    assign pp_en    = ref_ok && !hot;
    assign ss_reset = requests_discharge(state);
    assign hyst_en  = line_ok;
    assign bias_en  = line_ok && !hot;
    assign ref_en   = !hot;
    assign state_oh = state_to_oh(state);
endmodule

// File: rtl/cvtr_supervisor.sv
module cvtr_supervisor
    import cvtr_sup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_at_reg,
    input  logic       vcc_above_min,
    input  logic       vref_good,
    input  logic       ss_armed,
    input  logic       line_good,
    input  logic       tj_over,
    input  logic       tj_cooled,
    output logic       buck_en,
    output logic       pp_en,
    output logic       ss_reset,
    output logic       hyst_en,
    output logic       bias_en,
    output logic       ref_en,
    output logic [4:0] state_oh
);
    sup_flags_t           raw_flags;
    logic [NUM_FLAGS-1:0] filt_bits;
    sup_flags_t           filt_flags;
    sup_state_e           cur_state;

    assign raw_flags = '{
        tj_cooled:     tj_cooled,
        tj_over:       tj_over,
        line_good:     line_good,
        ss_armed:      ss_armed,
        vref_good:     vref_good,
        vcc_above_min: vcc_above_min,
        vcc_at_reg:    vcc_at_reg
    };

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        cvtr_sup_filter #(
            .STAGES   (SYNC_STAGES),
            .FILT_LEN (FILT_LEN)
        ) filt_i (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_flags[i]),
            .dout (filt_bits[i])
        );
    end

    assign filt_flags = sup_flags_t'(filt_bits);

    cvtr_sup_fsm fsm_i (
        .clk   (clk),
        .rst   (rst),
        .flg   (filt_flags),
        .state (cur_state)
    );

    cvtr_sup_decode dec_i (
        .state    (cur_state),
        .ref_ok   (filt_flags.vref_good),
        .line_ok  (filt_flags.line_good),
        .buck_en  (buck_en),
        .pp_en    (pp_en),
        .ss_reset (ss_reset),
        .hyst_en  (hyst_en),
        .bias_en  (bias_en),
        .ref_en   (ref_en),
        .state_oh (state_oh)
    );
endmodule

// File: rtl/cvtr_sup_checker.sv
module cvtr_sup_checker (
    input logic       clk,
    input logic       rst,
    input logic       buck_en,
    input logic       pp_en,
    input logic       ss_reset,
    input logic       bias_en,
    input logic       ref_en,
    input logic [4:0] state_oh
);
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1) else $error("state not one-hot"); // R11

    AST_BUCK_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        buck_en |-> state_oh[2]) else $error("buck enabled outside run"); // R3

    AST_RUN_FROM_RAMP: assert property (@(posedge clk) disable iff (rst)
        $rose(state_oh[2]) |-> $past(state_oh[1])) else $error("run entered not from ramp"); // R3

    AST_FAULT_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
        state_oh[3] |-> (ss_reset && !buck_en)) else $error("fault without discharge"); // R4

    AST_HOT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        state_oh[4] |-> (!buck_en && !pp_en && !bias_en && !ref_en && ss_reset)) else $error("outputs live when hot"); // R9

    AST_HOT_EXIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(state_oh[4]) |-> state_oh[0]) else $error("thermal exit not to idle"); // R9

    AST_REF_EN_COOL: assert property (@(posedge clk) disable iff (rst)
        !state_oh[4] |-> ref_en) else $error("ref disabled outside thermal"); // R10
endmodule

bind cvtr_supervisor cvtr_sup_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .buck_en  (buck_en),
    .pp_en    (pp_en),
    .ss_reset (ss_reset),
    .bias_en  (bias_en),
    .ref_en   (ref_en),
    .state_oh (state_oh)
);

// File: tb/cvtr_supervisor_tb_top.sv
`timescale 1ns/1ps
module cvtr_supervisor_tb_top;
    localparam int FILT_LEN = 4;
    localparam int SETTLE   = FILT_LEN + 8;

    localparam logic [4:0] OH_IDLE = 5'b00001;
    localparam logic [4:0] OH_RAMP = 5'b00010;
    localparam logic [4:0] OH_RUN  = 5'b00100;
    localparam logic [4:0] OH_FLT  = 5'b01000;
    localparam logic [4:0] OH_HOT  = 5'b10000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_at_reg = 0, vcc_above_min = 0, vref_good = 0, ss_armed = 0;
    logic line_good = 0, tj_over = 0, tj_cooled = 0;
    logic buck_en, pp_en, ss_reset, hyst_en, bias_en, ref_en;
    logic [4:0] state_oh;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cvtr_supervisor #(.SYNC_STAGES(2), .FILT_LEN(FILT_LEN)) dut_i (
        .clk(clk), .rst(rst),
        .vcc_at_reg(vcc_at_reg), .vcc_above_min(vcc_above_min),
        .vref_good(vref_good), .ss_armed(ss_armed), .line_good(line_good),
        .tj_over(tj_over), .tj_cooled(tj_cooled),
        .buck_en(buck_en), .pp_en(pp_en), .ss_reset(ss_reset),
        .hyst_en(hyst_en), .bias_en(bias_en), .ref_en(ref_en),
        .state_oh(state_oh)
    );

    task automatic chk(input string req, input string what,
                       input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "state", state_oh, OH_IDLE);
        chk("R1", "buck_en", {4'd0, buck_en}, 5'd0);
        chk("R1", "ss_reset", {4'd0, ss_reset}, 5'd1);
        chk("R1", "ref_en", {4'd0, ref_en}, 5'd1);
        chk("R10", "bias_en idle line low", {4'd0, bias_en}, 5'd0);
    endtask

    task automatic t_startup();
        vcc_at_reg = 1; vcc_above_min = 1; vref_good = 1; line_good = 1; ss_armed = 0;
        settle();
        chk("R3", "ramp state", state_oh, OH_RAMP);
        chk("R3", "buck off while ramping", {4'd0, buck_en}, 5'd0);
        chk("R3", "ss_reset released", {4'd0, ss_reset}, 5'd0);
        chk("R7", "pp_en on ref", {4'd0, pp_en}, 5'd1);
        chk("R8", "hyst_en on line", {4'd0, hyst_en}, 5'd1);
        chk("R10", "bias_en on line", {4'd0, bias_en}, 5'd1);
        ss_armed = 1;
        settle();
        chk("R3", "run state", state_oh, OH_RUN);
        chk("R3", "buck_en on", {4'd0, buck_en}, 5'd1);
    endtask

    task automatic t_filter_and_line();
        line_good = 0;
        repeat (FILT_LEN - 1) @(negedge clk);
        line_good = 1;
        settle();
        chk("R2", "short line glitch ignored state", state_oh, OH_RUN);
        chk("R2", "short line glitch ignored hyst", {4'd0, hyst_en}, 5'd1);
        ss_armed = 0;
        repeat (FILT_LEN - 1) @(negedge clk);
        ss_armed = 1;
        settle();
        chk("R2", "short ss glitch ignored buck", {4'd0, buck_en}, 5'd1);
        line_good = 0;
        repeat (1 + FILT_LEN) @(posedge clk);
        @(negedge clk);
        chk("R2", "hyst_en before due edge", {4'd0, hyst_en}, 5'd1);
        @(negedge clk);
        chk("R2", "hyst_en at due edge", {4'd0, hyst_en}, 5'd0);
        settle();
        chk("R4", "line fault state", state_oh, OH_FLT);
        chk("R4", "line fault buck off", {4'd0, buck_en}, 5'd0);
        chk("R4", "line fault discharge", {4'd0, ss_reset}, 5'd1);
        chk("R7", "pp_en ignores line", {4'd0, pp_en}, 5'd1);
        chk("R8", "hyst_en follows line low", {4'd0, hyst_en}, 5'd0);
        chk("R10", "bias_en off with line low", {4'd0, bias_en}, 5'd0);
        chk("R10", "ref_en kept with line low", {4'd0, ref_en}, 5'd1);
    endtask

    task automatic t_fault_restart();
        line_good = 1;
        settle();
        chk("R4", "held in fault while ss armed", state_oh, OH_FLT);
        ss_armed = 0;
        settle();
        chk("R4", "rearm to ramp", state_oh, OH_RAMP);
        chk("R4", "discharge released", {4'd0, ss_reset}, 5'd0);
        ss_armed = 1;
        settle();
        chk("R3", "run after restart", state_oh, OH_RUN);
    endtask

    task automatic t_supply_fault();
        vcc_above_min = 0; vcc_at_reg = 0;
        settle();
        chk("R4", "supply fault state", state_oh, OH_FLT);
        chk("R4", "supply fault buck off", {4'd0, buck_en}, 5'd0);
        vcc_above_min = 1; ss_armed = 0;
        settle();
        chk("R4", "needs regulation to rearm", state_oh, OH_FLT);
        vcc_at_reg = 1;
        settle();
        chk("R4", "rearm after supply back", state_oh, OH_RAMP);
        ss_armed = 1;
        settle();
        chk("R3", "run after supply restart", state_oh, OH_RUN);
    endtask

    task automatic t_ss_drop();
        ss_armed = 0;
        settle();
        chk("R5", "ss drop to ramp", state_oh, OH_RAMP);
        chk("R5", "ss drop buck off", {4'd0, buck_en}, 5'd0);
        chk("R5", "ss drop no discharge", {4'd0, ss_reset}, 5'd0);
        chk("R7", "pp_en ignores ss", {4'd0, pp_en}, 5'd1);
        ss_armed = 1;
        settle();
        chk("R5", "back to run", state_oh, OH_RUN);
    endtask

    task automatic t_ref_loss();
        vref_good = 0;
        settle();
        chk("R6", "ref loss to idle", state_oh, OH_IDLE);
        chk("R6", "ref loss buck off", {4'd0, buck_en}, 5'd0);
        chk("R6", "ref loss pp off", {4'd0, pp_en}, 5'd0);
        vref_good = 1;
        settle();
        chk("R6", "recover to run", state_oh, OH_RUN);
        chk("R7", "pp back with ref", {4'd0, pp_en}, 5'd1);
    endtask

    task automatic t_thermal();
        tj_over = 1;
        settle();
        chk("R9", "thermal state", state_oh, OH_HOT);
        chk("R9", "thermal enables",
            {1'b0, buck_en, pp_en, bias_en, ref_en}, 5'b00000);
        chk("R9", "thermal discharge", {4'd0, ss_reset}, 5'd1);
        tj_over = 0;
        settle();
        chk("R9", "held until cooled", state_oh, OH_HOT);
        tj_cooled = 1;
        settle();
        chk("R9", "restart after cooling", state_oh, OH_RUN);
        chk("R10", "ref_en after cooling", {4'd0, ref_en}, 5'd1);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1..: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_startup();
        t_filter_and_line();
        t_fault_restart();
        t_supply_fault();
        t_ss_drop();
        t_ref_loss();
        t_thermal();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule